// File: doc/BRIEF.md
# Stale Line Read Permission Table

This block decides, for every load, whether the processor may keep reading its own copy of a cache line that another agent has already invalidated. Each incoming invalidation carries a probe lifetime. The table stores the line address with that lifetime as a down-counting timer. While the timer runs, a load to the line gets an allow result and may use the stale data. Once the timer runs out, the load is denied and the line has to be fetched again.

Two heuristics stop stale reads where delay would hurt progress. A line that a store-conditional has touched is treated as synchronization data: its existing entry is dropped and it can never be read stale again. A load that repeats the previous load's PC and line is taken to be a poll: it is denied and its entry is dropped. Lookup is fully associative on the line address. When the table is full, the entry with the least time left is replaced. The cache data array and the coherence controller sit outside this block.

Top module: `stale_perm_table`

## Requirements
- R1: After reset the table holds no entries, so every load is denied.
- R2: An invalidation with a nonzero probe value creates an entry for its line. A load to that line in any later cycle gets `ld_allow` high combinationally in its own cycle. An invalidation with probe value 0 creates no entry.
- R3: An entry written with probe value P at a clock edge allows loads in the P cycles that follow that edge. From the next cycle on, loads are denied and the entry is freed.
- R4: A store-conditional to a line drops that line's entry at the next edge and records the line in a list of synchronization lines (SYNC_DEPTH deep). Later invalidations of a recorded line create no entry, and loads to it are denied.
- R5: A load with the same PC and the same line as the previous load is denied, and its entry is freed at the next edge. A later load to that line with another PC is therefore denied as well.
- R6: Lines are 64 bytes wide. Address bits [5:0] play no part in any match, and bit 6 and above select the line.
- R7: When all entries are in use, an invalidation for a new line replaces the entry with the smallest remaining timer. The replaced line is denied afterwards, and the other lines keep their permission.
- R8: An invalidation for a line that already has an entry reloads that entry's timer with the new probe value and does not create a second entry.
- R9: `ld_deny` is high exactly when `ld_valid` is high and `ld_allow` is low. With no load, both outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| inv_valid | input | 1 | Invalidation received this cycle |
| inv_addr | input | ADDR_W | Byte address of the invalidated line |
| inv_probe | input | TIMER_W | Probe lifetime carried by the invalidation, in cycles |
| ld_valid | input | 1 | Load lookup this cycle |
| ld_addr | input | ADDR_W | Load byte address |
| ld_pc | input | PC_W | PC of the load |
| sc_valid | input | 1 | Store-conditional notification |
| sc_addr | input | ADDR_W | Store-conditional byte address |
| ld_allow | output | 1 | Stale copy may be read |
| ld_deny | output | 1 | Load must refetch the line |

## Verification
The load patterns are chosen so that each reason for a deny can be told apart from the others. A run of loads with distinct PCs walks a short-lived entry up to its last allowed cycle and one cycle past it, which separates expiry from a timer that is off by one. A repeated PC and line is followed by a load with a fresh PC, which shows that the poll both denied the load and freed the entry. A store-conditional is followed by a re-invalidation of the same line and by an invalidation of a line that was never resident, which separates dropping the entry from remembering the line. The table is filled with staggered lifetimes and then overflowed, and each line is probed afterwards, so that replacing the smallest timer can be told apart from replacing by position.

// File: rtl/spt_pkg.sv
package spt_pkg;
   localparam int unsigned SPT_ADDR_W_DFLT   = 32;
   localparam int unsigned SPT_PC_W_DFLT     = 32;
   localparam int unsigned SPT_LINE_OFF_DFLT = 6;
   localparam int unsigned SPT_TIMER_W_DFLT  = 14;
   localparam int unsigned SPT_ENTRIES_DFLT  = 128;
   localparam int unsigned SPT_SYNC_DFLT     = 8;
endpackage

// File: rtl/spt_entry.sv
module spt_entry #(
   parameter int unsigned TAG_W   = 26,
   parameter int unsigned TIMER_W = 14
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic [TAG_W-1:0]   wr_tag,
   input  logic [TIMER_W-1:0] wr_timer,
   input  logic               kill,
   input  logic [TAG_W-1:0]   lk_tag,
   input  logic [TAG_W-1:0]   sc_tag,
   input  logic [TAG_W-1:0]   in_tag,
   output logic               live,
   output logic [TIMER_W-1:0] timer_q,
   output logic               hit_lk,
   output logic               hit_sc,
   output logic               hit_in
);
   logic             valid_q;
   logic [TAG_W-1:0] tag_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid_q <= 1'b0;
         tag_q   <= '0;
         timer_q <= '0;
      end else if (wr_en) begin
         valid_q <= 1'b1;
         tag_q   <= wr_tag;
         timer_q <= wr_timer;
      end else if (kill) begin
         valid_q <= 1'b0;
         timer_q <= '0;
      end else if (valid_q) begin
         timer_q <= timer_q - 1'b1;
         if (timer_q == TIMER_W'(1)) valid_q <= 1'b0;
      end
   end

   assign live   = valid_q;
   assign hit_lk = valid_q && (tag_q == lk_tag);
   assign hit_sc = valid_q && (tag_q == sc_tag);
   assign hit_in = valid_q && (tag_q == in_tag);

   // R3: a resident entry left alone loses exactly one count per cycle
   a_r3_timer_step: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_q && !wr_en && !kill && timer_q > TIMER_W'(1)) |=> (valid_q && timer_q == $past(timer_q) - 1'b1));
endmodule

// File: rtl/spt_victim.sv
module spt_victim #(
   parameter int unsigned ENTRIES = 128,
   parameter int unsigned TIMER_W = 14,
   localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic [ENTRIES-1:0]              live,
   input  logic [ENTRIES-1:0][TIMER_W-1:0] timers,
   output logic [IDX_W-1:0]                idx
);
   logic             free_seen;
   logic [IDX_W-1:0] free_idx;
   logic [IDX_W-1:0] min_idx;
   logic [TIMER_W-1:0] min_val;

   always_comb begin
      free_seen = 1'b0;
      free_idx  = '0;
      min_idx   = '0;
      min_val   = '1;
      for (int i = 0; i < int'(ENTRIES); i++) begin
         if (!live[i] && !free_seen) begin
            free_seen = 1'b1;
            free_idx  = IDX_W'(i);
         end
         if (live[i] && timers[i] < min_val) begin
            min_val = timers[i];
            min_idx = IDX_W'(i);
         end
      end
      idx = free_seen ? free_idx : min_idx;
   end

   // R7: a free slot is always used before any resident line is evicted
   a_r7_free_first: assert property (@(posedge clk) disable iff (!rst_n)
      (!(&live)) |-> !live[idx]);
endmodule

// File: rtl/spt_sync.sv
module spt_sync #(
   parameter int unsigned TAG_W = 26,
   parameter int unsigned DEPTH = 8,
   localparam int unsigned PTR_W = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sc_valid,
   input  logic [TAG_W-1:0] sc_tag,
   input  logic [TAG_W-1:0] qa_tag,
   input  logic [TAG_W-1:0] qb_tag,
   output logic             qa_sync,
   output logic             qb_sync
);
   logic [DEPTH-1:0][TAG_W-1:0] tags_q;
   logic [DEPTH-1:0]            val_q;
   logic [PTR_W-1:0]            ptr_q;
   logic                        sc_known, qa_hit, qb_hit;

   always_comb begin
      sc_known = 1'b0;
      qa_hit   = 1'b0;
      qb_hit   = 1'b0;
      for (int i = 0; i < int'(DEPTH); i++) begin
         sc_known = sc_known | (val_q[i] && tags_q[i] == sc_tag);
         qa_hit   = qa_hit   | (val_q[i] && tags_q[i] == qa_tag);
         qb_hit   = qb_hit   | (val_q[i] && tags_q[i] == qb_tag);
      end
   end

   assign qa_sync = qa_hit || (sc_valid && sc_tag == qa_tag);
   assign qb_sync = qb_hit || (sc_valid && sc_tag == qb_tag);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tags_q <= '0;
         val_q  <= '0;
         ptr_q  <= '0;
      end else if (sc_valid && !sc_known) begin
         tags_q[ptr_q] <= sc_tag;
         val_q[ptr_q]  <= 1'b1;
         ptr_q <= (ptr_q == PTR_W'(DEPTH - 1)) ? '0 : ptr_q + 1'b1;
      end
   end

   // R4: a recorded line stays flagged in the following cycle
   a_r4_sync_kept: assert property (@(posedge clk) disable iff (!rst_n)
      (sc_valid && qa_tag == sc_tag && sc_known) |=> ($stable(qa_tag) -> qa_sync));
endmodule

// File: rtl/spt_poll.sv
module spt_poll #(
   parameter int unsigned TAG_W = 26,
   parameter int unsigned PC_W  = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ld_valid,
   input  logic [TAG_W-1:0] ld_tag,
   input  logic [PC_W-1:0]  ld_pc,
   output logic             poll
);
   logic             last_v_q;
   logic [TAG_W-1:0] last_tag_q;
   logic [PC_W-1:0]  last_pc_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         last_v_q   <= 1'b0;
         last_tag_q <= '0;
         last_pc_q  <= '0;
      end else if (ld_valid) begin
         last_v_q   <= 1'b1;
         last_tag_q <= ld_tag;
         last_pc_q  <= ld_pc;
      end
   end

   assign poll = ld_valid && last_v_q && last_tag_q == ld_tag && last_pc_q == ld_pc;
endmodule

// File: rtl/stale_perm_table.sv
module stale_perm_table
   import spt_pkg::*;
#(
   parameter int unsigned ADDR_W     = SPT_ADDR_W_DFLT,
   parameter int unsigned PC_W       = SPT_PC_W_DFLT,
   parameter int unsigned LINE_OFF   = SPT_LINE_OFF_DFLT,
   parameter int unsigned TIMER_W    = SPT_TIMER_W_DFLT,
   parameter int unsigned ENTRIES    = SPT_ENTRIES_DFLT,
   parameter int unsigned SYNC_DEPTH = SPT_SYNC_DFLT
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               inv_valid,
   input  logic [ADDR_W-1:0]  inv_addr,
   input  logic [TIMER_W-1:0] inv_probe,
   input  logic               ld_valid,
   input  logic [ADDR_W-1:0]  ld_addr,
   input  logic [PC_W-1:0]    ld_pc,
   input  logic               sc_valid,
   input  logic [ADDR_W-1:0]  sc_addr,
   output logic               ld_allow,
   output logic               ld_deny
);
   localparam int unsigned TAG_W = ADDR_W - LINE_OFF;
   localparam int unsigned IDX_W = $clog2(ENTRIES);

   if (ENTRIES < 2)          begin : g_bad_entries  $error("ENTRIES must be at least 2");       end
   if (SYNC_DEPTH < 2)       begin : g_bad_sync     $error("SYNC_DEPTH must be at least 2");    end
   if (LINE_OFF >= ADDR_W)   begin : g_bad_off      $error("LINE_OFF must be below ADDR_W");    end
   if (TIMER_W < 1)          begin : g_bad_timer    $error("TIMER_W must be positive");         end

   logic [TAG_W-1:0] inv_tag, ld_tag, sc_tag;
   assign inv_tag = inv_addr[ADDR_W-1:LINE_OFF];
   assign ld_tag  = ld_addr[ADDR_W-1:LINE_OFF];
   assign sc_tag  = sc_addr[ADDR_W-1:LINE_OFF];

   logic unused_offsets;
   assign unused_offsets = ^{inv_addr[LINE_OFF-1:0], ld_addr[LINE_OFF-1:0], sc_addr[LINE_OFF-1:0]};

   logic [ENTRIES-1:0]              live, hit_lk, hit_sc, hit_in, wr_en, kill;
   logic [ENTRIES-1:0][TIMER_W-1:0] timers;
   logic [IDX_W-1:0]                victim_idx, refresh_idx, target_idx;
   logic                            lk_sync, in_sync, poll, do_ins, any_in;

   spt_sync #(.TAG_W(TAG_W), .DEPTH(SYNC_DEPTH)) u_sync (
      .clk(clk), .rst_n(rst_n), .sc_valid(sc_valid), .sc_tag(sc_tag),
      .qa_tag(ld_tag), .qb_tag(inv_tag), .qa_sync(lk_sync), .qb_sync(in_sync));

   spt_poll #(.TAG_W(TAG_W), .PC_W(PC_W)) u_poll (
      .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .ld_tag(ld_tag),
      .ld_pc(ld_pc), .poll(poll));

   spt_victim #(.ENTRIES(ENTRIES), .TIMER_W(TIMER_W)) u_victim (
      .clk(clk), .rst_n(rst_n), .live(live), .timers(timers), .idx(victim_idx));

   always_comb begin
      refresh_idx = '0;
      for (int i = 0; i < int'(ENTRIES); i++)
         if (hit_in[i]) refresh_idx = IDX_W'(i);
   end

   assign any_in     = |hit_in;
   assign target_idx = any_in ? refresh_idx : victim_idx;
   assign do_ins     = inv_valid && (inv_probe != '0) && !in_sync;

   for (genvar g = 0; g < int'(ENTRIES); g++) begin : g_entry
      assign wr_en[g] = do_ins && (target_idx == IDX_W'(g));
      assign kill[g]  = (sc_valid && hit_sc[g]) || (ld_valid && hit_lk[g] && (poll || lk_sync));
      spt_entry #(.TAG_W(TAG_W), .TIMER_W(TIMER_W)) u_entry (
         .clk(clk), .rst_n(rst_n), .wr_en(wr_en[g]), .wr_tag(inv_tag),
         .wr_timer(inv_probe), .kill(kill[g]), .lk_tag(ld_tag), .sc_tag(sc_tag),
         .in_tag(inv_tag), .live(live[g]), .timer_q(timers[g]),
         .hit_lk(hit_lk[g]), .hit_sc(hit_sc[g]), .hit_in(hit_in[g]));
   end

   assign ld_allow = ld_valid && (|hit_lk) && !lk_sync && !poll;
   assign ld_deny  = ld_valid && !ld_allow;

   // R8: a line is resident in at most one entry
   a_r8_single_copy: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(hit_lk));
   // R9: outputs are exclusive and only raised by a load
   a_r9_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !(ld_allow && ld_deny) && ((ld_allow || ld_deny) == ld_valid));
   // R4: a load right after a store-conditional to its line is never allowed
   a_r4_after_sc: assert property (@(posedge clk) disable iff (!rst_n)
      (ld_valid && $past(sc_valid) && ld_tag == $past(sc_tag)) |-> !ld_allow);
   // R5: a repeated PC and line is never allowed
   a_r5_poll_deny: assert property (@(posedge clk) disable iff (!rst_n)
      (ld_valid && $past(ld_valid) && ld_tag == $past(ld_tag) && ld_pc == $past(ld_pc)) |-> !ld_allow);
endmodule

// File: tb/test_stale_perm_table.sv
module test_stale_perm_table;
   localparam int AW = 32;
   localparam int PW = 32;
   localparam int TW = 14;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          inv_valid = 1'b0, ld_valid = 1'b0, sc_valid = 1'b0;
   logic [AW-1:0] inv_addr = '0, ld_addr = '0, sc_addr = '0;
   logic [TW-1:0] inv_probe = '0;
   logic [PW-1:0] ld_pc = '0;
   logic          ld_allow, ld_deny;

   int checks = 0;
   int errors = 0;
   bit    exp_q[$];
   string req_q[$];

   always #4 clk = ~clk;

   stale_perm_table #(.ADDR_W(AW), .PC_W(PW), .LINE_OFF(6), .TIMER_W(TW),
                      .ENTRIES(4), .SYNC_DEPTH(8)) i_stale_perm_table (
      .clk(clk), .rst_n(rst_n), .inv_valid(inv_valid), .inv_addr(inv_addr),
      .inv_probe(inv_probe), .ld_valid(ld_valid), .ld_addr(ld_addr), .ld_pc(ld_pc),
      .sc_valid(sc_valid), .sc_addr(sc_addr), .ld_allow(ld_allow), .ld_deny(ld_deny));

   task automatic quiet();
      inv_valid = 1'b0; ld_valid = 1'b0; sc_valid = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) begin @(negedge clk); quiet(); end
   endtask

   task automatic inv(input logic [AW-1:0] a, input logic [TW-1:0] p);
      @(negedge clk); quiet();
      inv_valid = 1'b1; inv_addr = a; inv_probe = p;
   endtask

   task automatic sc(input logic [AW-1:0] a);
      @(negedge clk); quiet();
      sc_valid = 1'b1; sc_addr = a;
   endtask

   task automatic ld(input logic [AW-1:0] a, input logic [PW-1:0] pc, input bit exp, input string req);
      @(negedge clk); quiet();
      ld_valid = 1'b1; ld_addr = a; ld_pc = pc;
      exp_q.push_back(exp); req_q.push_back(req);
   endtask

   // monitor: compares every load result against the scoreboard queue
   always @(negedge clk) begin
      #2;
      if (rst_n) begin
         if (ld_valid) begin
            if (exp_q.size() == 0) begin
               checks++; errors++;
               $display("FAIL scoreboard: load with no expected item, actual allow=%0b expected none", ld_allow);
            end else begin
               bit e; string r;
               e = exp_q.pop_front(); r = req_q.pop_front();
               checks++;
               if (ld_allow !== e || ld_deny !== !e) begin
                  errors++;
                  $display("FAIL %s addr=%h pc=%0d: actual allow=%0b deny=%0b expected allow=%0b deny=%0b",
                           r, ld_addr, ld_pc, ld_allow, ld_deny, e, !e);
               end
            end
         end else if (ld_allow !== 1'b0 || ld_deny !== 1'b0) begin
            checks++; errors++;
            $display("FAIL R9 idle: actual allow=%0b deny=%0b expected 0 0", ld_allow, ld_deny);
         end
      end
   end

   initial begin
      #(8 * 200000);
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      idle(3);
      @(negedge clk); rst_n = 1'b1;
      // R1: empty after reset
      ld(32'h1000, 1, 1'b0, "R1");
      // R2: insert and same-cycle allow; zero probe makes no entry
      inv(32'h2000, 50);
      ld(32'h2000, 2, 1'b1, "R2");
      inv(32'h3000, 0);
      ld(32'h3000, 3, 1'b0, "R2");
      // R6: offset bits ignored, bit 6 selects another line
      ld(32'h203C, 4, 1'b1, "R6");
      ld(32'h2040, 5, 1'b0, "R6");
      // R3: probe 3 allows three cycles, then denies
      inv(32'h4000, 3);
      ld(32'h4000, 6, 1'b1, "R3");
      ld(32'h4000, 7, 1'b1, "R3");
      ld(32'h4000, 8, 1'b1, "R3");
      ld(32'h4000, 9, 1'b0, "R3");
      // R5: polling denies and frees the entry
      inv(32'h5000, 100);
      ld(32'h5000, 10, 1'b1, "R5");
      ld(32'h5000, 10, 1'b0, "R5");
      ld(32'h5000, 11, 1'b0, "R5");
      // R4: store-conditional drops entry and blocks future entries
      inv(32'h6000, 100);
      ld(32'h6000, 12, 1'b1, "R4");
      sc(32'h6010);
      ld(32'h6000, 13, 1'b0, "R4");
      inv(32'h6000, 100);
      ld(32'h6000, 14, 1'b0, "R4");
      sc(32'h7000);
      inv(32'h7000, 100);
      ld(32'h7000, 15, 1'b0, "R4");
      // R8: re-invalidation reloads the timer
      inv(32'h8000, 1000);
      inv(32'h8000, 2);
      ld(32'h8000, 16, 1'b1, "R8");
      ld(32'h8000, 17, 1'b1, "R8");
      ld(32'h8000, 18, 1'b0, "R8");
      // R7: let everything expire, fill, overflow
      idle(150);
      inv(32'h9000, 500);
      inv(32'hA000, 400);
      inv(32'hB000, 300);
      inv(32'hC000, 600);
      inv(32'hD000, 700);
      ld(32'hB000, 20, 1'b0, "R7");
      ld(32'h9000, 21, 1'b1, "R7");
      ld(32'hA000, 22, 1'b1, "R7");
      ld(32'hC000, 23, 1'b1, "R7");
      ld(32'hD000, 24, 1'b1, "R7");
      idle(3);
      if (exp_q.size() != 0) begin
         checks++; errors++;
         $display("FAIL scoreboard: actual %0d pending expected 0", exp_q.size());
      end
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule